// File: doc/BRIEF.md
# Variable Aspect Ratio Dual-Port RAM

This block holds 4608 bits of storage behind two independent ports. The write port runs on its own clock and the read port on another. Each port picks its shape at run time through a 3-bit shape code, and the two codes need not agree. Data can therefore be written as single bits and read back as 18-bit words, or written as 9-bit halves and read as nibbles.

Storage is 256 rows of 18 bits. The 9- and 18-bit shapes see a row as two 9-bit halves. The 1-, 2- and 4-bit shapes use only the sixteen bits of a row that are not a ninth bit. These are bits 7:0 and 16:9, taken as one 16-bit lane vector with bit 7:0 at the low end. The low address bits pick the sub-word inside that vector, with lane 0 at the least significant end.

Each port has an active-low block select. The read output is either taken straight from the read register or passed through one more register, chosen by a pipeline select. An active-low reset, sampled on the read clock, clears the read output.

Top module: `vrd_dual_port_ram`

## Requirements
- R1: Shape code 3'b100 gives 256 words of 18 bits: address bits 7:0 select the row, and a write then a read at the same address return the full 18-bit value.
- R2: Shape code 3'b011 gives 512 words of 9 bits: address bits 8:1 select the row, and address bit 0 selects the low half (row bits 8:0, when 0) or the high half (row bits 17:9, when 1).
- R3: Shape codes 3'b000, 3'b001 and 3'b010 give 4096x1, 2048x2 and 1024x4. The row is the address divided by 16, 8 and 4, and the remainder is the lane. Lane k covers bits k*W to k*W+W-1 of the lane vector {row[16:9], row[7:0]}. Row bits 8 and 17 are never written in these shapes.
- R4: The write shape and the read shape are independent, so data written in one shape is read back through the mapping of the other shape.
- R5: Shape codes 3'b101, 3'b110 and 3'b111 are illegal. An illegal write shape leaves the memory unchanged, and an illegal read shape leaves the read register unchanged.
- R6: While a port's active-low block select is high, that port does nothing: writes are ignored and the read output holds its value.
- R7: A write occurs on a rising write-clock edge only when the active-low write enable is low. A read occurs on a rising read-clock edge only when the active-high read enable is high. Otherwise the memory and the read output are unchanged.
- R8: With the pipeline select low, read data appears on the output after the read-clock edge that performs the read. With the select high, it appears one read-clock edge later, and until then the output shows the previously read data.
- R9: While the active-low reset is low, each rising read-clock edge clears the read output to all zeros, whatever the pipeline select.
- R10: In narrow shapes the write data bits above the shape width are ignored, and the read output bits above the read width are driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset of the read output, sampled on rd_clk |
| wr_shape | input | 3 | Write shape code |
| wr_blk_n | input | 1 | Active-low write port select |
| wr_en_n | input | 1 | Active-low write enable |
| wr_addr | input | 12 | Write address |
| wr_data | input | 18 | Write data, low bits used in narrow shapes |
| rd_shape | input | 3 | Read shape code |
| rd_blk_n | input | 1 | Active-low read port select |
| rd_en | input | 1 | Active-high read enable |
| rd_pipe | input | 1 | Output register select: 0 direct, 1 one extra stage |
| rd_addr | input | 12 | Read address |
| rd_data | output | 18 | Read data, zero above the read width |

## Verification
On every read-clock cycle the assertions check that the read output is zero after a reset edge. They also check that it holds while the read port is deselected, while no read is enabled, and while an illegal read shape is applied. After a single-bit read they check that the bits above bit 0 are zero. Whether the shape mappings place data in the right row, half and lane, and whether write-side suppression really leaves memory untouched, can only be shown by the bench. It writes through one shape, reads through another and compares against its own model. The one-cycle delay of the extra output stage is also shown only by the bench scenarios.

// File: rtl/vrd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, shape codes and helpers for the variable
// aspect ratio dual-port RAM. Assumes an 18-bit row split into two 9-bit halves.
package vrd_pkg;
    localparam int DATA_W   = 18;                 // full row width
    localparam int HALF_W   = DATA_W / 2;         // half-row width
    localparam int ROWS     = 256;                // physical rows
    localparam int ROW_AW   = $clog2(ROWS);       // row address width
    localparam int LANE_BITS = DATA_W - 2;        // bits usable by narrow shapes
    localparam int ADDR_W   = ROW_AW + $clog2(LANE_BITS); // widest address
    localparam int LANE_W   = $clog2(LANE_BITS);  // sub-word index width
    localparam int SHAPE_W  = 3;

    typedef enum logic [SHAPE_W-1:0] {
        SHAPE_X1  = 3'd0,
        SHAPE_X2  = 3'd1,
        SHAPE_X4  = 3'd2,
        SHAPE_X9  = 3'd3,
        SHAPE_X18 = 3'd4
    } shape_e;

    // True for the five defined shape codes.
    function automatic logic shape_ok(input logic [SHAPE_W-1:0] code);
        return code <= SHAPE_X18;
    endfunction

    // Physical row bit that holds narrow lane-vector bit i (skips the ninth bit).
    function automatic int lane_pos(input int i);
        return (i < HALF_W - 1) ? i : i + 1;
    endfunction
endpackage

// File: rtl/vrd_addr_map.sv
`timescale 1ns/1ps
// Address map: splits a port address into row and sub-word lane for the
// selected shape and flags illegal shape codes. Purely combinational.
module vrd_addr_map
    import vrd_pkg::*;
(
    input  logic [SHAPE_W-1:0] shape,
    input  logic [ADDR_W-1:0]  addr,
    output logic [ROW_AW-1:0]  row,
    output logic [LANE_W-1:0]  lane,
    output logic               legal
);
    // Pick row and lane bits according to the shape.
    always_comb begin
        row  = '0;
        lane = '0;
        case (shape)
            SHAPE_X1:  begin row = addr[ADDR_W-1:4]; lane = addr[3:0]; end
            SHAPE_X2:  begin row = addr[ADDR_W-2:3]; lane = {1'b0, addr[2:0]}; end
            SHAPE_X4:  begin row = addr[ADDR_W-3:2]; lane = {2'b0, addr[1:0]}; end
            SHAPE_X9:  begin row = addr[ADDR_W-4:1]; lane = {3'b0, addr[0]}; end
            SHAPE_X18: begin row = addr[ROW_AW-1:0]; lane = '0; end
            default:   begin row = '0; lane = '0; end
        endcase
    end

    assign legal = shape_ok(shape);
endmodule

// File: rtl/vrd_write_lanes.sv
`timescale 1ns/1ps
// Write lane placement: turns port write data into a row-wide bit mask and
// positioned data for the selected shape. Illegal shapes yield an empty mask.
module vrd_write_lanes
    import vrd_pkg::*;
(
    input  logic [SHAPE_W-1:0] shape,
    input  logic [LANE_W-1:0]  lane,
    input  logic [DATA_W-1:0]  din,
    output logic [DATA_W-1:0]  mask,
    output logic [DATA_W-1:0]  bits
);
    // Build mask and data; narrow shapes only touch lane-vector positions.
    always_comb begin
        mask = '0;
        bits = '0;
        case (shape)
            SHAPE_X18: begin
                mask = '1;
                bits = din;
            end
            SHAPE_X9: begin
                if (lane[0]) begin
                    mask[DATA_W-1:HALF_W] = '1;
                    bits[DATA_W-1:HALF_W] = din[HALF_W-1:0];
                end else begin
                    mask[HALF_W-1:0] = '1;
                    bits[HALF_W-1:0] = din[HALF_W-1:0];
                end
            end
            SHAPE_X4: begin
                for (int i = 0; i < LANE_BITS; i++) begin
                    if (i / 4 == int'(lane[1:0])) begin
                        mask[lane_pos(i)] = 1'b1;
                        bits[lane_pos(i)] = din[i % 4];
                    end
                end
            end
            SHAPE_X2: begin
                for (int i = 0; i < LANE_BITS; i++) begin
                    if (i / 2 == int'(lane[2:0])) begin
                        mask[lane_pos(i)] = 1'b1;
                        bits[lane_pos(i)] = din[i % 2];
                    end
                end
            end
            SHAPE_X1: begin
                for (int i = 0; i < LANE_BITS; i++) begin
                    if (i == int'(lane)) begin
                        mask[lane_pos(i)] = 1'b1;
                        bits[lane_pos(i)] = din[0];
                    end
                end
            end
            default: begin
                mask = '0;
                bits = '0;
            end
        endcase
    end
endmodule

// File: rtl/vrd_read_lanes.sv
`timescale 1ns/1ps
// Read lane extraction: selects the sub-word of a row for the read shape and
// zero-fills the bits above the read width.
module vrd_read_lanes
    import vrd_pkg::*;
(
    input  logic [SHAPE_W-1:0] shape,
    input  logic [LANE_W-1:0]  lane,
    input  logic [DATA_W-1:0]  word,
    output logic [DATA_W-1:0]  dout
);
    logic [LANE_BITS-1:0] vec;

    // Gather the sixteen narrow-shape bits into one vector.
    assign vec = {word[DATA_W-2:HALF_W], word[HALF_W-2:0]};

    // Select the lane for the read shape.
    always_comb begin
        dout = '0;
        case (shape)
            SHAPE_X18: dout = word;
            SHAPE_X9:  dout[HALF_W-1:0] = lane[0] ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
            SHAPE_X4:  dout[3:0] = vec[{lane[1:0], 2'b00} +: 4];
            SHAPE_X2:  dout[1:0] = vec[{lane[2:0], 1'b0} +: 2];
            SHAPE_X1:  dout[0]   = vec[lane];
            default:   dout = '0;
        endcase
    end
endmodule

// File: rtl/vrd_store.sv
`timescale 1ns/1ps
// Storage array: ROWS x DATA_W bits with a bit-masked write on wr_clk and an
// asynchronous row read. Contents are not cleared by reset.
module vrd_store
    import vrd_pkg::*;
(
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ROW_AW-1:0] wrow,
    input  logic [DATA_W-1:0] wmask,
    input  logic [DATA_W-1:0] wbits,
    input  logic [ROW_AW-1:0] rrow,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] mem [ROWS];

    // Merge the masked bits into the addressed row.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[wrow] <= (mem[wrow] & ~wmask) | (wbits & wmask);
        end
    end

    assign rword = mem[rrow];
endmodule

// File: rtl/vrd_dual_port_ram.sv
`timescale 1ns/1ps
// Top: dual-clock RAM with independent write and read shapes. Assumes the
// caller avoids reading a row on the same instant it is being written.
// The read output has a direct register and an optional second stage.
module vrd_dual_port_ram
    import vrd_pkg::*;
(
    input  logic               wr_clk,
    input  logic               rd_clk,
    input  logic               rst_n,
    input  logic [SHAPE_W-1:0] wr_shape,
    input  logic               wr_blk_n,
    input  logic               wr_en_n,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SHAPE_W-1:0] rd_shape,
    input  logic               rd_blk_n,
    input  logic               rd_en,
    input  logic               rd_pipe,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data
);
    logic [ROW_AW-1:0] w_row, r_row;
    logic [LANE_W-1:0] w_lane, r_lane;
    logic              w_legal, r_legal;
    logic [DATA_W-1:0] w_mask, w_bits, r_word, r_lane_data;
    logic [DATA_W-1:0] rd_stage1, rd_stage2;
    logic              w_go, r_go;

    vrd_addr_map u_wmap (
        .shape(wr_shape), .addr(wr_addr), .row(w_row), .lane(w_lane), .legal(w_legal)
    );

    vrd_addr_map u_rmap (
        .shape(rd_shape), .addr(rd_addr), .row(r_row), .lane(r_lane), .legal(r_legal)
    );

    vrd_write_lanes u_wlanes (
        .shape(wr_shape), .lane(w_lane), .din(wr_data), .mask(w_mask), .bits(w_bits)
    );

    vrd_store u_store (
        .wr_clk(wr_clk), .we(w_go), .wrow(w_row), .wmask(w_mask), .wbits(w_bits),
        .rrow(r_row), .rword(r_word)
    );

    vrd_read_lanes u_rlanes (
        .shape(rd_shape), .lane(r_lane), .word(r_word), .dout(r_lane_data)
    );

    assign w_go = !wr_blk_n && !wr_en_n && w_legal;
    assign r_go = !rd_blk_n && rd_en && r_legal;

    // First read register: captures lane data on an enabled, legal read.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_stage1 <= '0;
        end else if (r_go) begin
            rd_stage1 <= r_lane_data;
        end
    end

    // Second read register: follows the first while the port is selected.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_stage2 <= '0;
        end else if (!rd_blk_n) begin
            rd_stage2 <= rd_stage1;
        end
    end

    assign rd_data = rd_pipe ? rd_stage2 : rd_stage1;
endmodule

// File: rtl/vrd_checker.sv
`timescale 1ns/1ps
// Checker: read-side properties of vrd_dual_port_ram, bound to every instance.
module vrd_checker
    import vrd_pkg::*;
(
    input logic               rd_clk,
    input logic               rst_n,
    input logic [SHAPE_W-1:0] rd_shape,
    input logic               rd_blk_n,
    input logic               rd_en,
    input logic               rd_pipe,
    input logic [DATA_W-1:0]  rd_data
);
    // R9: a reset edge leaves the output at zero on the next edge.
    assert_reset_zero_R9: assert property (@(posedge rd_clk)
        !rst_n |=> (rd_data == '0));

    // R6: a deselected read port holds its output.
    assert_blk_hold_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_blk_n) && ($past(rd_pipe) == rd_pipe))
        |-> (rd_data == $past(rd_data)));

    // R7: without a read enable the direct output holds.
    assert_no_read_hold_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rd_en) && !$past(rd_pipe) && !rd_pipe)
        |-> (rd_data == $past(rd_data)));

    // R5: an illegal read shape leaves the direct output unchanged.
    assert_illegal_hold_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(rd_shape) > 3'd4) && !$past(rd_pipe) && !rd_pipe)
        |-> (rd_data == $past(rd_data)));

    // R10: a single-bit read drives the upper bits to zero.
    assert_x1_upper_zero_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ($past(rst_n && rd_en && !rd_blk_n && (rd_shape == 3'd0) && !rd_pipe) && !rd_pipe)
        |-> (rd_data[DATA_W-1:1] == '0));
endmodule

bind vrd_dual_port_ram vrd_checker i_vrd_checker (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_shape(rd_shape), .rd_blk_n(rd_blk_n),
    .rd_en(rd_en), .rd_pipe(rd_pipe), .rd_data(rd_data)
);

// File: tb/test_vrd_dual_port_ram.sv
`timescale 1ns/1ps
// Directed bench for vrd_dual_port_ram with its own shadow model of storage.
module test_vrd_dual_port_ram;
    logic        wr_clk, rd_clk, rst_n;
    logic [2:0]  wr_shape, rd_shape;
    logic        wr_blk_n, wr_en_n, rd_blk_n, rd_en, rd_pipe;
    logic [11:0] wr_addr, rd_addr;
    logic [17:0] wr_data, rd_data;

    int checks = 0;
    int errors = 0;
    logic [17:0] mdl [256];

    vrd_dual_port_ram i_vrd_dual_port_ram (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_shape(wr_shape), .wr_blk_n(wr_blk_n), .wr_en_n(wr_en_n),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_shape(rd_shape), .rd_blk_n(rd_blk_n), .rd_en(rd_en),
        .rd_pipe(rd_pipe), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // 125 MHz clocks; the read clock is offset from the write clock.
    initial begin wr_clk = 0; forever #4 wr_clk = ~wr_clk; end
    initial begin rd_clk = 0; #1.5; forever #4 rd_clk = ~rd_clk; end

    function automatic int npos(input int i);
        return (i < 8) ? i : i + 1;
    endfunction

    function automatic logic [17:0] pat(input int r);
        return 18'((r * 7919) ^ (r << 9) ^ 18'h15A5A);
    endfunction

    // Model write following R1..R3, R5..R7, R10.
    function automatic void mdl_write(input int m, input int a, input logic [17:0] d);
        int w, per, row, lane;
        if (m == 4) mdl[a % 256] = d;
        else if (m == 3) begin
            row = (a / 2) % 256;
            if (a % 2) mdl[row][17:9] = d[8:0]; else mdl[row][8:0] = d[8:0];
        end else if (m <= 2) begin
            w = 1 << m; per = 16 / w; row = (a / per) % 256; lane = a % per;
            for (int b = 0; b < w; b++) mdl[row][npos(lane * w + b)] = d[b];
        end
    endfunction

    function automatic logic [17:0] mdl_read(input int m, input int a);
        logic [17:0] v;
        int w, per, row, lane;
        v = '0;
        if (m == 4) v = mdl[a % 256];
        else if (m == 3) begin
            row = (a / 2) % 256;
            v[8:0] = (a % 2) ? mdl[row][17:9] : mdl[row][8:0];
        end else begin
            w = 1 << m; per = 16 / w; row = (a / per) % 256; lane = a % per;
            for (int b = 0; b < w; b++) v[b] = mdl[row][npos(lane * w + b)];
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int m, input int a, input logic [17:0] d,
                            input logic blk = 1'b0, input logic en_n = 1'b0);
        @(negedge wr_clk);
        wr_shape = 3'(m); wr_addr = 12'(a); wr_data = d; wr_blk_n = blk; wr_en_n = en_n;
        @(negedge wr_clk);
        wr_blk_n = 1'b1; wr_en_n = 1'b1;
        if (m <= 4 && !blk && !en_n) mdl_write(m, a, d);
    endtask

    task automatic do_read(input int m, input int a, output logic [17:0] q);
        @(negedge rd_clk);
        rd_shape = 3'(m); rd_addr = 12'(a); rd_pipe = 1'b0; rd_en = 1'b1; rd_blk_n = 1'b0;
        @(negedge rd_clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic t_reset_state();
        chk("R9 reset output direct", rd_data, 18'h0);
        rd_pipe = 1'b1; #1;
        chk("R9 reset output piped", rd_data, 18'h0);
        rd_pipe = 1'b0;
    endtask

    task automatic t_fill_x18();
        logic [17:0] q;
        for (int r = 0; r < 256; r++) do_write(4, r, pat(r));
        foreach (q[i]) ;
        do_read(4, 0, q);   chk("R1 x18 row 0", q, mdl_read(4, 0));
        do_read(4, 1, q);   chk("R1 x18 row 1", q, mdl_read(4, 1));
        do_read(4, 128, q); chk("R1 x18 row 128", q, mdl_read(4, 128));
        do_read(4, 255, q); chk("R1 x18 row 255", q, mdl_read(4, 255));
    endtask

    task automatic t_x9_halves();
        logic [17:0] q;
        do_write(3, 10, 18'h001A5);
        do_write(3, 11, 18'h000C3);
        do_read(3, 10, q); chk("R2 x9 low half", q, 18'h001A5);
        do_read(3, 11, q); chk("R2 x9 high half", q, 18'h000C3);
        do_read(4, 5, q);  chk("R4 x9 write read as x18", q, {9'h0C3, 9'h1A5});
    endtask

    task automatic t_narrow_write();
        logic [17:0] q;
        do_write(2, 20 * 4 + 3, 18'h0000A);
        do_write(1, 21 * 8 + 5, 18'h00001);
        do_write(0, 22 * 16 + 8, 18'h00001);
        do_write(0, 22 * 16 + 7, 18'h00000);
        do_read(4, 20, q); chk("R3 x4 lane 3 in row", q, mdl_read(4, 20));
        do_read(4, 21, q); chk("R3 x2 lane 5 in row", q, mdl_read(4, 21));
        do_read(4, 22, q); chk("R3 x1 lanes 7 and 8 in row", q, mdl_read(4, 22));
        do_read(2, 20 * 4 + 3, q); chk("R3 x4 read back", q, 18'h0000A);
        do_read(0, 22 * 16 + 8, q); chk("R3 x1 read back", q, 18'h00001);
    endtask

    task automatic t_mixed_read();
        logic [17:0] q;
        for (int l = 0; l < 16; l += 5) begin
            do_read(0, 40 * 16 + l, q); chk("R4 x18 data read as x1", q, mdl_read(0, 40 * 16 + l));
        end
        for (int l = 0; l < 8; l += 3) begin
            do_read(1, 41 * 8 + l, q); chk("R4 x18 data read as x2", q, mdl_read(1, 41 * 8 + l));
        end
        for (int l = 0; l < 4; l++) begin
            do_read(2, 42 * 4 + l, q); chk("R10 x4 read upper zero", q, mdl_read(2, 42 * 4 + l));
        end
    endtask

    task automatic t_upper_ignored();
        logic [17:0] q;
        do_write(0, 100 * 16 + 2, 18'h3FFFE);
        do_read(4, 100, q); chk("R10 x1 write ignores upper bits", q, mdl_read(4, 100));
        do_write(3, 2 * 101, 18'h3FE55);
        do_read(4, 101, q); chk("R10 x9 write ignores upper bits", q, mdl_read(4, 101));
    endtask

    task automatic t_pipe_latency();
        logic [17:0] a0, b0;
        do_read(4, 0, a0);
        b0 = mdl_read(4, 1);
        @(negedge rd_clk);
        rd_shape = 3'd4; rd_addr = 12'd1; rd_pipe = 1'b1; rd_en = 1'b1; rd_blk_n = 1'b0;
        @(negedge rd_clk);
        rd_en = 1'b0;
        chk("R8 piped output still old after read edge", rd_data, a0);
        @(negedge rd_clk);
        chk("R8 piped output new one edge later", rd_data, b0);
        rd_pipe = 1'b0;
    endtask

    task automatic t_block_disable();
        logic [17:0] q, held;
        do_write(4, 60, 18'h12345, 1'b1, 1'b0);
        do_read(4, 60, q); chk("R6 write ignored while deselected", q, mdl_read(4, 60));
        do_read(4, 61, held);
        @(negedge rd_clk);
        rd_addr = 12'd62; rd_en = 1'b1; rd_blk_n = 1'b1;
        @(negedge rd_clk);
        chk("R6 read output held while deselected", rd_data, held);
        rd_en = 1'b0; rd_blk_n = 1'b0;
    endtask

    task automatic t_enables_off();
        logic [17:0] q, held;
        do_write(4, 63, 18'h2BCDE, 1'b0, 1'b1);
        do_read(4, 63, q); chk("R7 write ignored with enable high", q, mdl_read(4, 63));
        held = q;
        @(negedge rd_clk);
        rd_addr = 12'd64; rd_en = 1'b0;
        @(negedge rd_clk);
        chk("R7 output held without read enable", rd_data, held);
    endtask

    task automatic t_illegal_codes();
        logic [17:0] q, held;
        for (int m = 5; m < 8; m++) do_write(m, 70, 18'h3FFFF);
        do_read(4, 0, q); chk("R5 illegal write shape leaves row 0", q, mdl_read(4, 0));
        do_read(4, 70, q); chk("R5 illegal write shape leaves row 70", q, mdl_read(4, 70));
        held = q;
        @(negedge rd_clk);
        rd_shape = 3'd6; rd_addr = 12'd71; rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        chk("R5 illegal read shape holds output", rd_data, held);
    endtask

    task automatic t_reset_midrun();
        logic [17:0] q;
        do_read(4, 255, q);
        @(negedge rd_clk);
        rst_n = 1'b0;
        @(negedge rd_clk);
        chk("R9 mid-run reset clears output", rd_data, 18'h0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(8 * 100000);
        checks++; errors++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Main sequence.
    initial begin
        rst_n = 1'b0;
        wr_shape = 3'd4; wr_blk_n = 1'b1; wr_en_n = 1'b1; wr_addr = '0; wr_data = '0;
        rd_shape = 3'd4; rd_blk_n = 1'b0; rd_en = 1'b0; rd_pipe = 1'b0; rd_addr = '0;
        for (int r = 0; r < 256; r++) mdl[r] = '0;
        repeat (3) @(negedge rd_clk);
        t_reset_state();
        rst_n = 1'b1;
        t_fill_x18();
        t_x9_halves();
        t_narrow_write();
        t_mixed_read();
        t_upper_ignored();
        t_pipe_latency();
        t_block_disable();
        t_enables_off();
        t_illegal_codes();
        t_reset_midrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule